// File: doc/BRIEF.md
# Switch-Driven Quadrant Pixel Colorizer

This block supplies the color of each pixel to a VGA timing generator. On every clock the timing generator presents the column and row of the next pixel. One cycle later the block returns an 8-bit color for that pixel. A 100-by-100 pixel square anchored at the screen origin is divided into four equal quadrants. Two external switch levels form a two-bit code, and that code chooses which quadrant is painted red. The other three quadrants are painted white, and every pixel outside the square is black.

The switch levels arrive with no relation to the pixel clock, so each one passes through its own multi-flop synchronizer. The synchronized code then loads a four-flag highlight grid, which holds one flag per quadrant. For each pixel a combinational classifier names the region that the pixel falls in: `REG_TL`, `REG_TR`, `REG_BL`, `REG_BR` or `REG_OUT`. The output stage then registers the color that belongs to that region. The classifier's transitions are positional. A column at or beyond the half size moves a pixel from a left region to a right one. A row at or beyond the half size moves it from an upper region to a lower one. Either coordinate at or beyond the full size moves the pixel to `REG_OUT`.

Top module: `quad_colorizer`

## Requirements
- R1: The color output packs red in bits [7:5], green in bits [4:2] and blue in bits [1:0]. After reset it only ever takes the values 8'hE0 (red), 8'hFF (white) or 8'h00 (black).
- R2: A pixel whose column is 100 or more, or whose row is 100 or more, is colored 8'h00.
- R3: Inside the square, a pixel lies in the right half when its column is at least 50 and in the lower half when its row is at least 50.
- R4: The code {sw_hi, sw_lo} selects the highlighted quadrant: 2'b00 top-left, 2'b01 top-right, 2'b10 bottom-left, 2'b11 bottom-right. Pixels of the selected quadrant are colored 8'hE0.
- R5: Pixels inside the square but outside the selected quadrant are colored 8'hFF.
- R6: The color for the coordinates present at a rising edge appears on the output right after that edge, which is one cycle of latency.
- R7: The switch code present at rising edge t governs the colors produced from edge t+3 onward. This delay comes from two synchronizer stages and the grid register.
- R8: While rst_n is low, the output is 8'h00, the synchronizers are cleared and the grid selects the top-left quadrant.
- R9: Exactly one flag of the highlight grid is set at every edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_hi | input | 1 | Upper bit of the quadrant code, asynchronous |
| sw_lo | input | 1 | Lower bit of the quadrant code, asynchronous |
| px_x | input | 10 | Column of the next pixel |
| px_y | input | 10 | Row of the next pixel |
| pix_color | output | 8 | Registered RGB color, 3-3-2 packing |

## Verification
Two events can land in the same cycle: a new switch code reaching the highlight grid, and a pixel being painted from that grid. The bench provokes this by changing the switch code every few cycles while it feeds a pseudo-random stream of coordinates, both inside and outside the square. For each sampled pixel it takes the code that was driven exactly three edges before that pixel's coordinates. The exact old-versus-new boundary therefore has to match. A static sweep over every pixel of a slightly enlarged square, repeated for all four codes, checks the quadrant edges at 49/50 and 99/100.

// File: rtl/cq_pkg.sv
package cq_pkg;

    typedef enum logic [2:0] {
        REG_TL  = 3'd0,
        REG_TR  = 3'd1,
        REG_BL  = 3'd2,
        REG_BR  = 3'd3,
        REG_OUT = 3'd4
    } region_e;

    localparam int COLOR_W = 8;

    localparam logic [COLOR_W-1:0] COLOR_RED   = 8'hE0;
    localparam logic [COLOR_W-1:0] COLOR_WHITE = 8'hFF;
    localparam logic [COLOR_W-1:0] COLOR_BLACK = 8'h00;

endpackage

// File: rtl/cq_sync.sv
module cq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[b]};
                end
            end

            assign sync_out[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cq_grid.sv
module cq_grid #(
    parameter int CODE_W = 2,
    localparam int QUADS = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic [QUADS-1:0]  grid
);

    logic [QUADS-1:0] grid_next;

    always_comb begin
        grid_next = '0;
        for (int q = 0; q < QUADS; q++) begin
            if (code == CODE_W'(q)) grid_next[q] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid <= QUADS'(1);
        end else begin
            grid <= grid_next;
        end
    end

    assert_grid_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grid) == 1);

    assert_grid_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> grid[$past(code)]);

endmodule

// File: rtl/cq_region.sv
module cq_region
    import cq_pkg::*;
#(
    parameter int X_W    = 10,
    parameter int Y_W    = 10,
    parameter int SQUARE = 100
) (
    input  logic [X_W-1:0] px_x,
    input  logic [Y_W-1:0] px_y,
    output region_e        region
);

    localparam int HALF = SQUARE / 2;
    localparam logic [X_W-1:0] X_END  = X_W'(SQUARE);
    localparam logic [Y_W-1:0] Y_END  = Y_W'(SQUARE);
    localparam logic [X_W-1:0] X_HALF = X_W'(HALF);
    localparam logic [Y_W-1:0] Y_HALF = Y_W'(HALF);

    logic outside;
    logic right_half;
    logic lower_half;

    always_comb begin
        outside    = (px_x >= X_END) || (px_y >= Y_END);
        right_half = (px_x >= X_HALF);
        lower_half = (px_y >= Y_HALF);
        if (outside) begin
            region = REG_OUT;
        end else begin
            unique case ({lower_half, right_half})
                2'b00:   region = REG_TL;
                2'b01:   region = REG_TR;
                2'b10:   region = REG_BL;
                default: region = REG_BR;
            endcase
        end
    end

endmodule

// File: rtl/cq_paint.sv
module cq_paint
    import cq_pkg::*;
#(
    parameter int QUADS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  region_e            region,
    input  logic [QUADS-1:0]   grid,
    output logic [COLOR_W-1:0] color
);

    logic [COLOR_W-1:0] color_next;

    always_comb begin
        unique case (region)
            REG_OUT: color_next = COLOR_BLACK;
            REG_TL:  color_next = grid[0] ? COLOR_RED : COLOR_WHITE;
            REG_TR:  color_next = grid[1] ? COLOR_RED : COLOR_WHITE;
            REG_BL:  color_next = grid[2] ? COLOR_RED : COLOR_WHITE;
            REG_BR:  color_next = grid[3] ? COLOR_RED : COLOR_WHITE;
            default: color_next = COLOR_BLACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            color <= COLOR_BLACK;
        end else begin
            color <= color_next;
        end
    end

    assert_palette_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (color == COLOR_RED) || (color == COLOR_WHITE) || (color == COLOR_BLACK));

    assert_outside_black_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_OUT) |=> (color == COLOR_BLACK));

    assert_selected_red_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (region != REG_OUT && grid[region[1:0]]) |=> (color == COLOR_RED));

    assert_others_white_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (region != REG_OUT && !grid[region[1:0]]) |=> (color == COLOR_WHITE));

    always_comb begin
        if (!rst_n) assert_reset_black_R8: assert (color == COLOR_BLACK);
    end

endmodule

// File: rtl/quad_colorizer.sv
module quad_colorizer
    import cq_pkg::*;
#(
    parameter int X_W         = 10,
    parameter int Y_W         = 10,
    parameter int SQUARE      = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_hi,
    input  logic         sw_lo,
    input  logic [X_W-1:0] px_x,
    input  logic [Y_W-1:0] px_y,
    output logic [7:0]   pix_color
);

    localparam int CODE_W = 2;
    localparam int QUADS  = 1 << CODE_W;

    logic [CODE_W-1:0] code_sync;
    logic [QUADS-1:0]  grid;
    region_e           region;

    cq_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sw_hi, sw_lo}),
        .sync_out (code_sync)
    );

    cq_grid #(.CODE_W(CODE_W)) u_grid (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (code_sync),
        .grid  (grid)
    );

    cq_region #(.X_W(X_W), .Y_W(Y_W), .SQUARE(SQUARE)) u_region (
        .px_x   (px_x),
        .px_y   (px_y),
        .region (region)
    );

    cq_paint #(.QUADS(QUADS)) u_paint (
        .clk    (clk),
        .rst_n  (rst_n),
        .region (region),
        .grid   (grid),
        .color  (pix_color)
    );

endmodule

// File: tb/quad_colorizer_test.sv
module quad_colorizer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_hi = 1'b0;
    logic       sw_lo = 1'b0;
    logic [9:0] px_x = '0;
    logic [9:0] px_y = '0;
    logic [7:0] pix_color;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [1:0] sh [0:3];
    logic [9:0] prev_x, prev_y;
    logic       have_prev = 1'b0;

    quad_colorizer uut (
        .clk(clk), .rst_n(rst_n), .sw_hi(sw_hi), .sw_lo(sw_lo),
        .px_x(px_x), .px_y(px_y), .pix_color(pix_color)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] expect_color(input int x, input int y, input logic [1:0] code);
        logic [1:0] quad;
        if (x >= 100 || y >= 100) return 8'h00;
        quad = {y >= 50, x >= 50};
        return (quad == code) ? 8'hE0 : 8'hFF;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: x=%0d y=%0d actual=%h expected=%h", req, prev_x, prev_y, act, exp);
        end
    endtask

    function automatic string req_of(input int x, input int y);
        if (x >= 100 || y >= 100) return "R2";
        if (x == 49 || x == 50 || y == 49 || y == 50) return "R3";
        return "R4/R5/R6/R7";
    endfunction

    task automatic step(input int x, input int y, input logic [1:0] code);
        @(negedge clk);
        if (have_prev)
            check(req_of(prev_x, prev_y), pix_color, expect_color(prev_x, prev_y, sh[3]));
        sh[3] = sh[2]; sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = code;
        px_x = 10'(x); px_y = 10'(y);
        {sw_hi, sw_lo} = code;
        prev_x = 10'(x); prev_y = 10'(y);
        have_prev = 1'b1;
    endtask

    task automatic do_reset(input logic [1:0] hold_code);
        @(negedge clk);
        rst_n = 1'b0;
        {sw_hi, sw_lo} = hold_code;
        px_x = 10'd10; px_y = 10'd10;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            prev_x = px_x; prev_y = px_y;
            check("R8 reset", pix_color, 8'h00);
        end
        for (int i = 0; i < 4; i++) sh[i] = 2'b00;
        have_prev = 1'b0;
        {sw_hi, sw_lo} = 2'b00;
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [1:0]  cur;
        do_reset(2'b00);
        // R8: grid after reset selects top-left (switches held low)
        step(10, 10, 2'b00);
        step(60, 10, 2'b00);
        // R2 R3 R4 R5 R6: exhaustive sweep per code over a 110x110 window
        for (int c = 0; c < 4; c++) begin
            for (int w = 0; w < 5; w++) step(200, 200, 2'(c));
            for (int y = 0; y < 110; y++)
                for (int x = 0; x < 110; x++) step(x, y, 2'(c));
        end
        // R1 R2: far coordinates
        step(1023, 5, 2'b11);
        step(5, 1023, 2'b11);
        step(99, 99, 2'b11);
        step(100, 0, 2'b11);
        // R8: reset in the middle with switches high, grid returns to top-left
        do_reset(2'b11);
        step(0, 0, 2'b00);
        step(99, 99, 2'b00);
        step(0, 0, 2'b00);
        // R7: switch changes coinciding with painting, pseudo-random pixels
        lfsr = 16'hACE1;
        cur  = 2'b00;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) cur = lfsr[9:8];
            step(int'(lfsr[15:9]), int'(lfsr[14:8]) % 120, cur);
        end
        step(0, 0, cur);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule